// File: doc/BRIEF.md
# DMA Bus Arbiter with Debug Halt Gate

This block decides, cycle by cycle, who owns a single shared system bus: one of three DMA channels, the CPU, or a debug halt requester. Each channel is programmed through a small write port with an enable, a transfer mode, a repeat flag and a transfer size. A trigger input per channel starts work. A grant on `dma_gnt_o` stands for one word moved in that cycle, and the channel's word counter counts down with each grant.

Three modes exist. Single moves one word per trigger rising edge. Block moves the whole programmed size back to back. Burst-block moves the whole size, but splits bus time in a fixed ten-cycle frame: eight DMA cycles, then two CPU cycles. With the repeat flag set, the counter reloads at completion. Block and burst-block work then carries straight on. A debug halt is granted only after a quiet period with no DMA request and only while the CPU is not asking for the bus, so a repeated burst-block channel left enabled keeps a debug halt out for good.

Top module: `dma_bus_arbiter`

## Requirements
- R1: In any cycle at most one of DMA, CPU or debug owns the bus. When no channel holds the bus, the requesting channel with the lowest index wins, so a trigger routed to channels 0 and 2 is served by channel 0 and then by channel 2 in the next cycle.
- R2: In single mode (mode code 0), a trigger rising edge captured at a clock edge produces one grant to that channel in the following cycle.
- R3: In block mode (mode code 1; code 3 behaves the same), one trigger edge produces exactly size grants in consecutive cycles. No other channel is granted until the block ends.
- R4: In burst-block mode (mode code 2), bus time follows a ten-cycle frame that begins with the first grant: eight DMA cycles, then two CPU cycles. The CPU slots stay idle when the CPU is not requesting. A block of S words therefore takes S + 2*floor((S-1)/8) cycles.
- R5: In non-repeated operation, the cycle after the last word the channel raises `done_o` for exactly one cycle and clears its enable. Later triggers then produce no grant.
- R6: With the repeat flag set, the counter reloads when a transfer completes and `done_o` stays low. Block and burst-block continue with no new trigger; single waits for the next edge.
- R7: `dbg_gnt_o` is high only when `dbg_req_i` is high, the CPU is not requesting, no channel is requesting, and no channel has requested in the previous three cycles.
- R8: A repeated burst-block channel that stays enabled keeps requesting the bus in every cycle, so a pending debug halt is never granted.
- R9: A pulse on `en_clr_i` lets the word granted in that cycle complete. From the next cycle the channel makes no request, and the quiet period for R7 counts from that cycle.
- R10: A channel programmed with size 0 ignores its trigger and never requests the bus until it is written again.
- R11: In single mode, a second trigger edge that arrives while an earlier word is still waiting for the bus marks the channel as lost. It then ignores every later trigger until it is written again.
- R12: The CPU is granted whenever it requests and no channel requests, and also in the CPU slots of a burst-block frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | NCH | One-hot per-channel configuration write strobe |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_mode_i | input | 2 | Mode to write: 0 single, 1 block, 2 burst-block |
| cfg_rpt_i | input | 1 | Repeat flag to write |
| cfg_size_i | input | SW | Transfer size to write (also loads the counter) |
| en_clr_i | input | NCH | Per-channel enable clear pulse |
| trig_i | input | NCH | Per-channel trigger level; rising edge acts |
| cpu_req_i | input | 1 | CPU bus request |
| cpu_gnt_o | output | 1 | CPU bus grant |
| dbg_req_i | input | 1 | Debug halt request |
| dbg_gnt_o | output | 1 | Debug halt grant |
| dma_gnt_o | output | NCH | Per-channel grant, one word per cycle |
| done_o | output | NCH | One-cycle completion pulse per channel |

## Verification
The assertions assume that a channel is written only while it is idle, that `cfg_we_i` is one-hot or zero, and that a channel's mode does not change while that channel owns the bus. Under these conditions the no-preemption and single-owner properties follow from the inputs alone. The stimulus writes a channel only after its `done_o`, after `en_clr_i`, or before its first trigger. It holds each trigger low for at least one cycle between edges, so the edge detector sees every pulse that is meant to count.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_BURST  = 2'd2,
    MODE_RSVD   = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_arb_pkg::*;
#(
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  xfer_mode_e    cfg_mode_i,
  input  logic          cfg_rpt_i,
  input  logic [SW-1:0] cfg_size_i,
  input  logic          en_clr_i,
  input  logic          trig_i,
  input  logic          gnt_i,
  output logic          req_o,
  output logic          blk_o,
  output logic          burst_o,
  output logic          done_o
);
  localparam logic [SW-1:0] ONE = SW'(1);

  xfer_mode_e    mode_q;
  logic          en_q, rpt_q, trig_q, pend_q, run_q, lost_q, done_q;
  logic [SW-1:0] size_q, cnt_q;
  logic          single, last, edge_ok;

  assign single  = (mode_q == MODE_SINGLE);
  assign last    = (cnt_q == ONE);
  assign edge_ok = trig_i & ~trig_q & en_q & (size_q != '0) & ~lost_q
                 & ~(gnt_i & last & ~rpt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SINGLE;
      en_q   <= 1'b0;
      rpt_q  <= 1'b0;
      trig_q <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      lost_q <= 1'b0;
      done_q <= 1'b0;
      size_q <= '0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_i;
      done_q <= 1'b0;
      if (cfg_we_i) begin
        en_q   <= cfg_en_i;
        mode_q <= cfg_mode_i;
        rpt_q  <= cfg_rpt_i;
        size_q <= cfg_size_i;
        cnt_q  <= cfg_size_i;
        pend_q <= 1'b0;
        run_q  <= 1'b0;
        lost_q <= 1'b0;
      end else begin
        if (gnt_i) begin
          if (last) begin
            if (rpt_q) cnt_q <= size_q;
            else begin
              cnt_q  <= '0;
              en_q   <= 1'b0;
              run_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
          if (single) pend_q <= 1'b0;
        end
        if (edge_ok) begin
          if (single) begin
            if (pend_q && !gnt_i) begin
              lost_q <= 1'b1;  // sequence broken: drop it for good
              pend_q <= 1'b0;
            end else begin
              pend_q <= 1'b1;
            end
          end else if (!run_q) begin
            run_q <= 1'b1;
          end
        end
        if (en_clr_i) begin  // granted word above still completes
          en_q   <= 1'b0;
          pend_q <= 1'b0;
          run_q  <= 1'b0;
        end
      end
    end
  end

  assign req_o   = en_q & (pend_q | run_q);
  assign blk_o   = ~single;
  assign burst_o = (mode_q == MODE_BURST);
  assign done_o  = done_q;

  assert_done_clears_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !en_q);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_zero_size_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q == '0) |-> !req_o);
  assert_lost_no_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> !pend_q);
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned NCH       = 3,
  parameter int unsigned DMA_SLOTS = 8,
  parameter int unsigned CPU_SLOTS = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] blk_i,
  input  logic [NCH-1:0] burst_i,
  input  logic           cpu_req_i,
  output logic [NCH-1:0] dma_gnt_o,
  output logic           cpu_gnt_o
);
  localparam int unsigned PER = DMA_SLOTS + CPU_SLOTS;
  localparam int unsigned PW  = $clog2(PER);
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1;

  logic          lock_q, locked, any, cpu_slot;
  logic [CW-1:0] lock_id_q, pick, sel;
  logic [PW-1:0] phase_q, phase_eff, phase_nxt;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) pick = CW'(i);
    end
  end

  // owner keeps the bus while it still requests; fresh pick otherwise
  assign locked    = lock_q & req_i[lock_id_q];
  assign sel       = locked ? lock_id_q : pick;
  assign any       = |req_i;
  assign phase_eff = locked ? phase_q : '0;
  assign cpu_slot  = any & burst_i[sel] & (phase_eff >= PW'(DMA_SLOTS));
  assign phase_nxt = (phase_eff == PW'(PER - 1)) ? '0 : phase_eff + PW'(1);

  assign dma_gnt_o = (any && !cpu_slot) ? (NCH'(1) << sel) : '0;
  assign cpu_gnt_o = cpu_req_i & (~any | cpu_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      lock_id_q <= '0;
      phase_q   <= '0;
    end else begin
      lock_q    <= any & blk_i[sel];
      lock_id_q <= sel;
      phase_q   <= (any & burst_i[sel]) ? phase_nxt : '0;
    end
  end

  assert_cpu_slot_no_dma_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && req_i[lock_id_q] && burst_i[lock_id_q] && phase_q >= PW'(DMA_SLOTS))
      |-> (dma_gnt_o == '0));
endmodule

// File: rtl/dma_quiet.sv
module dma_quiet #(
  parameter int unsigned QUIET = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_req_i,
  input  logic cpu_req_i,
  input  logic dbg_req_i,
  output logic dbg_gnt_o
);
  localparam int unsigned QW = $clog2(QUIET + 1);

  logic [QW-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q_q <= '0;
    else if (any_req_i)           q_q <= '0;
    else if (q_q != QW'(QUIET))   q_q <= q_q + QW'(1);
  end

  assign dbg_gnt_o = dbg_req_i & (q_q == QW'(QUIET)) & ~cpu_req_i & ~any_req_i;

  assert_dbg_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_gnt_o |-> (!$past(any_req_i, 1) && !$past(any_req_i, 2) && !$past(any_req_i, 3)));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH       = 3,
  parameter int unsigned SW        = 8,
  parameter int unsigned DMA_SLOTS = 8,
  parameter int unsigned CPU_SLOTS = 2,
  parameter int unsigned QUIET     = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cfg_we_i,
  input  logic           cfg_en_i,
  input  logic [1:0]     cfg_mode_i,
  input  logic           cfg_rpt_i,
  input  logic [SW-1:0]  cfg_size_i,
  input  logic [NCH-1:0] en_clr_i,
  input  logic [NCH-1:0] trig_i,
  input  logic           cpu_req_i,
  output logic           cpu_gnt_o,
  input  logic           dbg_req_i,
  output logic           dbg_gnt_o,
  output logic [NCH-1:0] dma_gnt_o,
  output logic [NCH-1:0] done_o
);
  logic [NCH-1:0] req, blk, burst;
  xfer_mode_e     mode_w;

  assign mode_w = xfer_mode_e'(cfg_mode_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan #(.SW(SW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i[c]),
      .cfg_en_i   (cfg_en_i),
      .cfg_mode_i (mode_w),
      .cfg_rpt_i  (cfg_rpt_i),
      .cfg_size_i (cfg_size_i),
      .en_clr_i   (en_clr_i[c]),
      .trig_i     (trig_i[c]),
      .gnt_i      (dma_gnt_o[c]),
      .req_o      (req[c]),
      .blk_o      (blk[c]),
      .burst_o    (burst[c]),
      .done_o     (done_o[c])
    );

    assert_no_preempt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(dma_gnt_o[c] & blk[c]) && req[c]) |-> ((dma_gnt_o & ~(NCH'(1) << c)) == '0));
  end

  dma_arb #(.NCH(NCH), .DMA_SLOTS(DMA_SLOTS), .CPU_SLOTS(CPU_SLOTS)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .blk_i     (blk),
    .burst_i   (burst),
    .cpu_req_i (cpu_req_i),
    .dma_gnt_o (dma_gnt_o),
    .cpu_gnt_o (cpu_gnt_o)
  );

  dma_quiet #(.QUIET(QUIET)) u_quiet (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_req_i (|req),
    .cpu_req_i (cpu_req_i),
    .dbg_req_i (dbg_req_i),
    .dbg_gnt_o (dbg_gnt_o)
  );

  assert_one_owner_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_gnt_o, cpu_gnt_o, dbg_gnt_o}));
endmodule

// File: tb/sim_dma_bus_arbiter.sv
module sim_dma_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int SW  = 8;
  localparam int M_SINGLE = 0, M_BLOCK = 1, M_BURST = 2;

  logic           clk = 1'b0;
  logic           rst_ni;
  logic [NCH-1:0] cfg_we, en_clr, trig, dma_gnt, done;
  logic           cfg_en, cfg_rpt, cpu_req, cpu_gnt, dbg_req, dbg_gnt;
  logic [1:0]     cfg_mode;
  logic [SW-1:0]  cfg_size;
  int nvec = 0, nerr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_bus_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .cfg_mode_i(cfg_mode), .cfg_rpt_i(cfg_rpt), .cfg_size_i(cfg_size),
    .en_clr_i(en_clr), .trig_i(trig), .cpu_req_i(cpu_req), .cpu_gnt_o(cpu_gnt),
    .dbg_req_i(dbg_req), .dbg_gnt_o(dbg_gnt), .dma_gnt_o(dma_gnt), .done_o(done)
  );

  task automatic chk(input string r, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic prog(input int ch, input bit en, input int mode, input bit rpt, input int size);
    @(negedge clk);
    cfg_we = '0; cfg_we[ch] = 1'b1;
    cfg_en = en; cfg_mode = 2'(mode); cfg_rpt = rpt; cfg_size = SW'(size);
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic sweep_single(input int ch, input int size);
    prog(ch, 1, M_SINGLE, 0, size);
    for (int w = 0; w < size; w++) begin
      @(negedge clk); trig[ch] = 1'b1;
      @(negedge clk); trig[ch] = 1'b0;
      chk("R2 single grant", int'(dma_gnt), 1 << ch);
      @(negedge clk);
      chk("R5 single done", int'(done[ch]), (w == size - 1) ? 1 : 0);
    end
  endtask

  task automatic sweep_blk(input int ch, input int mode, input int size, input bit cpu);
    int g, c, cyc, seen, ecyc, ecpu;
    string tag;
    tag  = (mode == M_BURST) ? "R4" : "R3";
    ecyc = (mode == M_BURST) ? size + 2 * ((size - 1) / 8) : size;
    ecpu = (cpu && mode == M_BURST) ? 2 * ((size - 1) / 8) : 0;
    prog(ch, 1, mode, 0, size);
    cpu_req = cpu;
    @(negedge clk); trig[ch] = 1'b1;
    g = 0; c = 0; cyc = 0; seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); trig[ch] = 1'b0;
      if (done[ch]) begin seen = 1; break; end
      g += int'(dma_gnt[ch]); c += int'(cpu_gnt); cyc++;
    end
    chk({tag, " words"}, g, size);
    chk({tag, " cycles"}, cyc, ecyc);
    chk({tag, " cpu slots"}, c, ecpu);
    chk("R5 done seen", seen, 1);
    @(negedge clk);
    chk("R5 done one cycle", int'(done[ch]), 0);
    trig[ch] = 1'b1;
    g = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); trig[ch] = 1'b0; g += int'(dma_gnt[ch]);
    end
    chk("R5 disabled after done", g, 0);
    cpu_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int g, g2, d, idle, cg;
    rst_ni = 1'b0; cfg_we = '0; en_clr = '0; trig = '0; cfg_en = 1'b0;
    cfg_rpt = 1'b0; cfg_mode = '0; cfg_size = '0; cpu_req = 1'b0; dbg_req = 1'b0;
    repeat (3) @(negedge clk);
    cpu_req = 1'b1; #1;
    chk("R12 reset cpu grant", int'(cpu_gnt), 1);
    chk("R1 reset dma idle", int'(dma_gnt), 0);
    chk("R5 reset done low", int'(done), 0);
    @(negedge clk); rst_ni = 1'b1; cpu_req = 1'b0;

    for (int ch = 0; ch < NCH; ch++)
      for (int s = 1; s <= 4; s++) sweep_single(ch, s);

    for (int ch = 0; ch < NCH; ch++)
      for (int m = M_BLOCK; m <= M_BURST; m++)
        for (int s = 1; s <= 20; s++)
          for (int cp = 0; cp < 2; cp++) sweep_blk(ch, m, s, cp[0]);

    // R1: shared trigger to channels 0 and 2
    prog(0, 1, M_SINGLE, 0, 1);
    prog(2, 1, M_SINGLE, 0, 1);
    @(negedge clk); trig = 3'b101;
    @(negedge clk); trig = '0;
    chk("R1 ch0 first", int'(dma_gnt), 1);
    @(negedge clk);
    chk("R1 ch2 second", int'(dma_gnt), 4);

    // R3: block on ch2 not preempted by ch0
    prog(2, 1, M_BLOCK, 0, 6);
    prog(0, 1, M_SINGLE, 0, 1);
    @(negedge clk); trig[2] = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      trig[2] = 1'b0;
      chk("R3 no preempt", int'(dma_gnt), (i <= 6) ? 4 : 1);
      trig[0] = (i == 2);
    end
    trig = '0;

    // R11: lost trigger sequence
    prog(0, 1, M_BLOCK, 0, 12);
    prog(1, 1, M_SINGLE, 0, 4);
    @(negedge clk); trig[0] = 1'b1;
    g = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      trig[0] = 1'b0;
      g += int'(dma_gnt[1]);
      trig[1] = (i == 2 || i == 4 || i == 20 || i == 22 || i == 30);
    end
    trig = '0;
    chk("R11 lost ignores later", g, 0);
    prog(1, 1, M_SINGLE, 0, 1);
    @(negedge clk); trig[1] = 1'b1;
    @(negedge clk); trig[1] = 1'b0;
    chk("R11 recovers after write", int'(dma_gnt), 2);

    // R10: zero size
    for (int m = M_SINGLE; m <= M_BURST; m++) begin
      prog(1, 1, m, 0, 0);
      @(negedge clk); trig[1] = 1'b1;
      g = 0; d = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk); trig[1] = 1'b0;
        g += int'(dma_gnt[1]); d += int'(done[1]);
      end
      chk("R10 zero size no grant", g, 0);
      chk("R10 zero size no done", d, 0);
    end

    // R6: repeated single
    prog(2, 1, M_SINGLE, 1, 2);
    g = 0; d = 0;
    for (int w = 0; w < 5; w++) begin
      @(negedge clk); trig[2] = 1'b1;
      @(negedge clk); trig[2] = 1'b0; g += int'(dma_gnt[2]);
      @(negedge clk); d += int'(done[2]);
    end
    chk("R6 repeated single words", g, 5);
    chk("R6 repeated single no done", d, 0);
    en_clr[2] = 1'b1; @(negedge clk); en_clr = '0;

    // R6: repeated block runs on, CPU locked out
    prog(1, 1, M_BLOCK, 1, 2);
    cpu_req = 1'b1;
    @(negedge clk); trig[1] = 1'b1;
    g = 0; cg = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk); trig[1] = 1'b0;
      g += int'(dma_gnt[1]); cg += int'(cpu_gnt);
    end
    chk("R6 repeated block words", g, 30);
    chk("R6 repeated block cpu", cg, 0);
    en_clr[1] = 1'b1;
    @(negedge clk); en_clr = '0;
    chk("R9 clear stops block", int'(dma_gnt), 0);
    chk("R12 cpu after clear", int'(cpu_gnt), 1);
    cpu_req = 1'b0;

    // R8: repeated burst starves debug
    prog(0, 1, M_BURST, 1, 3);
    dbg_req = 1'b1;
    @(negedge clk); trig[0] = 1'b1;
    g = 0; d = 0; idle = 0; cg = 0; g2 = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk); trig[0] = 1'b0;
      g += int'(dma_gnt[0]); d += int'(dbg_gnt); cg += int'(cpu_gnt);
      idle += (dma_gnt == '0) ? 1 : 0;
    end
    chk("R8 burst words in 100 cycles", g, 80);
    chk("R8 debug starved", d, 0);
    chk("R4 idle cpu slots", idle, 20);
    chk("R4 no cpu without request", cg, 0);
    @(negedge clk);
    chk("R9 current word completes", int'(dma_gnt[0]), 1);
    en_clr[0] = 1'b1;
    @(negedge clk); en_clr = '0;
    chk("R9 released", int'(dma_gnt), 0);
    chk("R7 quiet 1", int'(dbg_gnt), 0);
    @(negedge clk);
    chk("R7 quiet 2", int'(dbg_gnt), 0);
    @(negedge clk);
    chk("R7 quiet 3", int'(dbg_gnt), 0);
    @(negedge clk);
    chk("R7 debug granted", int'(dbg_gnt), 1);
    cpu_req = 1'b1; #1;
    chk("R7 cpu blocks debug", int'(dbg_gnt), 0);
    chk("R12 cpu granted idle bus", int'(cpu_gnt), 1);
    @(negedge clk);
    cpu_req = 1'b0; dbg_req = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule